// File: doc/BRIEF.md
# Serial Management Frame to Register Bus Bridge

This block sits behind the two-wire PHY management port. It oversamples the serial data line on the system clock and uses a one-cycle strobe, `ce`, that marks each rising edge of the management clock. It decodes read and write frames into one access each on a simple cycle/strobe/acknowledge register bus. For a read it sends the returned word back on the data line. The line is driven through an output enable that lags the internal decision by a fixed number of system clocks, so that an external level shifter can change direction first.

Each frame is laid out MSB first as follows: at least `PRE_LEN` ones, a start pair `01`, a 2-bit operation, a 5-bit PHY address, a 5-bit register address, a 2-bit turnaround and a 16-bit data word. A frame can be bad because its start bit, operation or PHY address is wrong. The state machine still steps through every field of a bad frame, so bits that are out of step are never taken as a new frame. The bad flag only blocks the bus access and the line drive.

The states are `ST_PREAMBLE` (counts ones), `ST_START` (second start bit), `ST_OPCODE`, `ST_PHYAD`, `ST_REGAD`, `ST_TURN` and `ST_DATA`. The transitions are:
- preamble→start, on a zero that follows at least `PRE_LEN` ones.
- start→opcode, opcode→phyad, phyad→regad, regad→turn and turn→data, each when the field's bit counter reaches zero.
- data→preamble, after the last data bit.

A register address is latched at regad→turn, and a read request is raised at the same time. The drive decision is taken on the first turnaround bit. A write request is raised at data→preamble.

Top module: `mdio_bus_bridge`

## Requirements
- R1: While reset is held, `mdio_oe` is 0 and `bus_cyc` is 0.
- R2: A frame is accepted only after at least `PRE_LEN` (32) consecutive ones sampled on `ce`, followed by the start pair 0 then 1. A frame with only 31 ones in its preamble starts no bus cycle.
- R3: A read (operation bits `10`) with a matching PHY address starts one bus read with `bus_we`=0 and `bus_adr` equal to the register address. The line then carries 0 in the second turnaround bit period, then data bits 15 down to 0, with `mdio_oe`=1 over those 17 bit periods and 0 again after the last data bit.
- R4: A write (operation bits `01`) with a matching PHY address starts one bus write after the last data bit, with `bus_we`=1, the register address, and the 16 received data bits on `bus_wdata`.
- R5: A frame whose PHY address differs from `phy_addr` starts no bus cycle and never raises `mdio_oe`.
- R6: A frame with operation `00` or `11`, or with a start pair other than `01`, starts no bus cycle. The frame that follows it is still decoded correctly.
- R7: If a bus read ends with `bus_err` instead of `bus_ack`, `mdio_oe` stays 0 for the whole turnaround and data phase.
- R8: A bus write that ends with `bus_err` has no further effect, and the next frame is handled normally.
- R9: `mdio_o` and `mdio_oe` follow the internal drive decision made at a `ce` edge exactly 2 system clocks later.
- R10: The frame state changes only on cycles with `ce` high. A bus cycle stays asserted until `bus_ack` or `bus_err` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | One-cycle strobe at each management clock rising edge |
| mdio_i | input | 1 | Sampled management data line |
| phy_addr | input | 5 | Address this PHY answers to |
| mdio_o | output | 1 | Data driven onto the line |
| mdio_oe | output | 1 | Line drive enable |
| bus_cyc | output | 1 | Bus cycle active |
| bus_stb | output | 1 | Bus strobe |
| bus_we | output | 1 | Bus write enable |
| bus_adr | output | 5 | Bus register address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data |
| bus_ack | input | 1 | Bus acknowledge |
| bus_err | input | 1 | Bus error response |

## Verification
The bench spaces `ce` every 8 system clocks and drives each bit just before its `ce` edge. The drive decision made at that edge reaches `mdio_oe` two clocks later. The bench therefore samples the enable at the second and third falling edge after the strobe, to pin the exact lag. It samples the line value at the seventh falling edge, well before the next strobe. The bench slave answers on the second clock of a cycle, so every bus cycle is expected to be high for exactly three clocks. A read response is complete four clocks after the last address bit, long before the turnaround decision that uses it.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
    typedef enum logic [2:0] {
        ST_PREAMBLE,
        ST_START,
        ST_OPCODE,
        ST_PHYAD,
        ST_REGAD,
        ST_TURN,
        ST_DATA
    } frame_state_t;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
endpackage

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_bridge_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              mdio_i,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic              rsp_ok,
    input  logic              rsp_err,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              rd_req,
    output logic              wr_req,
    output logic [ADDR_W-1:0] req_adr,
    output logic [DATA_W-1:0] wr_data,
    output logic              drv_oe,
    output logic              drv_bit
);
    localparam int CNT_W  = $clog2(DATA_W);
    localparam int ONES_W = $clog2(PRE_LEN + 1);

    frame_state_t      state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [ONES_W-1:0] ones_q, ones_d;
    logic [DATA_W-1:0] shift_q, shift_d, out_q, out_d, wdat_q, wdat_d;
    logic [ADDR_W-1:0] adr_q, adr_d;
    logic              read_q, read_d, bad_q, bad_d;
    logic              rd_q, rd_d, wr_q, wr_d, oe_q, oe_d, bit_q, bit_d;
    logic [DATA_W-1:0] shift_in;

    assign shift_in = {shift_q[DATA_W-2:0], mdio_i};

    // Next-state and next-output logic, evaluated on ce only
    always_comb begin
        state_d = state_q;  cnt_d  = cnt_q;   ones_d = ones_q;
        shift_d = shift_q;  out_d  = out_q;   wdat_d = wdat_q;
        adr_d   = adr_q;    read_d = read_q;  bad_d  = bad_q;
        oe_d    = oe_q;     bit_d  = bit_q;
        rd_d    = 1'b0;     wr_d   = 1'b0;
        if (ce) begin
            unique case (state_q)
                ST_PREAMBLE: begin
                    oe_d  = 1'b0;
                    bad_d = 1'b0;
                    if (mdio_i) begin
                        if (ones_q != ONES_W'(PRE_LEN)) ones_d = ones_q + 1'b1;
                    end else begin
                        if (ones_q == ONES_W'(PRE_LEN)) state_d = ST_START;
                        ones_d = '0;
                    end
                end
                ST_START: begin
                    if (!mdio_i) bad_d = 1'b1;
                    state_d = ST_OPCODE;
                    cnt_d   = CNT_W'(1);
                end
                ST_OPCODE: begin
                    shift_d = shift_in;
                    cnt_d   = cnt_q - 1'b1;
                    if (cnt_q == '0) begin
                        read_d = (shift_in[1:0] == OP_READ);
                        if (shift_in[1:0] != OP_READ && shift_in[1:0] != OP_WRITE) bad_d = 1'b1;
                        state_d = ST_PHYAD;
                        cnt_d   = CNT_W'(ADDR_W - 1);
                    end
                end
                ST_PHYAD: begin
                    shift_d = shift_in;
                    cnt_d   = cnt_q - 1'b1;
                    if (cnt_q == '0) begin
                        if (shift_in[ADDR_W-1:0] != phy_addr) bad_d = 1'b1;
                        state_d = ST_REGAD;
                        cnt_d   = CNT_W'(ADDR_W - 1);
                    end
                end
                ST_REGAD: begin
                    shift_d = shift_in;
                    cnt_d   = cnt_q - 1'b1;
                    if (cnt_q == '0) begin
                        adr_d   = shift_in[ADDR_W-1:0];
                        rd_d    = read_q && !bad_q;
                        state_d = ST_TURN;
                        cnt_d   = CNT_W'(1);
                    end
                end
                ST_TURN: begin
                    cnt_d = cnt_q - 1'b1;
                    if (cnt_q != '0) begin
                        if (read_q && !bad_q && rsp_ok && !rsp_err) begin
                            oe_d  = 1'b1;
                            bit_d = 1'b0;
                            out_d = rsp_data;
                        end else if (read_q) begin
                            bad_d = 1'b1;
                        end
                    end else begin
                        bit_d   = out_q[DATA_W-1];
                        out_d   = {out_q[DATA_W-2:0], 1'b0};
                        state_d = ST_DATA;
                        cnt_d   = CNT_W'(DATA_W - 1);
                    end
                end
                ST_DATA: begin
                    shift_d = shift_in;
                    cnt_d   = cnt_q - 1'b1;
                    bit_d   = out_q[DATA_W-1];
                    out_d   = {out_q[DATA_W-2:0], 1'b0};
                    if (cnt_q == '0) begin
                        oe_d    = 1'b0;
                        wr_d    = !read_q && !bad_q;
                        wdat_d  = shift_in;
                        state_d = ST_PREAMBLE;
                        ones_d  = '0;
                    end
                end
                default: state_d = ST_PREAMBLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PREAMBLE; cnt_q <= '0; ones_q <= '0;
            shift_q <= '0; out_q <= '0; wdat_q <= '0; adr_q <= '0;
            read_q <= 1'b0; bad_q <= 1'b0; rd_q <= 1'b0; wr_q <= 1'b0;
            oe_q <= 1'b0; bit_q <= 1'b0;
        end else begin
            state_q <= state_d; cnt_q <= cnt_d; ones_q <= ones_d;
            shift_q <= shift_d; out_q <= out_d; wdat_q <= wdat_d; adr_q <= adr_d;
            read_q <= read_d; bad_q <= bad_d; rd_q <= rd_d; wr_q <= wr_d;
            oe_q <= oe_d; bit_q <= bit_d;
        end
    end

    assign rd_req  = rd_q;
    assign wr_req  = wr_q;
    assign req_adr = adr_q;
    assign wr_data = wdat_q;
    assign drv_oe  = oe_q;
    assign drv_bit = bit_q;

    AST_CE_GATES_STATE: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(state_q)); // R10
    AST_DRIVE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        oe_q |-> (state_q == ST_TURN || state_q == ST_DATA)); // R3
    AST_WRITE_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
        wr_q |-> $past(state_q) == ST_DATA); // R4
    AST_READ_AFTER_REGAD: assert property (@(posedge clk) disable iff (rst)
        rd_q |-> $past(state_q) == ST_REGAD); // R3
endmodule

// File: rtl/mdio_bus_port.sv
module mdio_bus_port #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] req_adr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_cyc,
    output logic              bus_stb,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_adr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              rsp_ok,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_cyc <= 1'b0; bus_we <= 1'b0; bus_adr <= '0; bus_wdata <= '0;
            rsp_ok <= 1'b0; rsp_err <= 1'b0; rsp_data <= '0;
        end else if (rd_req || wr_req) begin
            bus_cyc   <= 1'b1;
            bus_we    <= wr_req;
            bus_adr   <= req_adr;
            bus_wdata <= wr_data;
            rsp_ok    <= 1'b0;
            rsp_err   <= 1'b0;
        end else if (bus_cyc && bus_ack) begin
            bus_cyc <= 1'b0;
            rsp_ok  <= 1'b1;
            if (!bus_we) rsp_data <= bus_rdata;
        end else if (bus_cyc && bus_err) begin
            // held until the frame logic reaches its next decision on ce
            bus_cyc <= 1'b0;
            rsp_err <= 1'b1;
        end
    end

    assign bus_stb = bus_cyc;

    AST_CYC_HELD: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && !bus_ack && !bus_err && !rd_req && !wr_req) |=> bus_cyc); // R10
    AST_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (rd_req || wr_req) |-> !bus_cyc); // R10
endmodule

// File: rtl/mdio_out_delay.sv
module mdio_out_delay #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic oe_in,
    input  logic bit_in,
    output logic oe_out,
    output logic bit_out
);
    logic [STAGES-1:0] oe_pipe, bit_pipe;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    oe_pipe <= '0; bit_pipe <= '0;
                end else begin
                    oe_pipe <= oe_in; bit_pipe <= bit_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    oe_pipe <= '0; bit_pipe <= '0;
                end else begin
                    oe_pipe  <= {oe_pipe[STAGES-2:0], oe_in};
                    bit_pipe <= {bit_pipe[STAGES-2:0], bit_in};
                end
            end
        end
    endgenerate

    assign oe_out  = oe_pipe[STAGES-1];
    assign bit_out = bit_pipe[STAGES-1];
endmodule

// File: rtl/mdio_bus_bridge.sv
module mdio_bus_bridge #(
    parameter int PRE_LEN    = 32,
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 16,
    parameter int OUT_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              mdio_i,
    input  logic [ADDR_W-1:0] phy_addr,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              bus_cyc,
    output logic              bus_stb,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_adr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err
);
    logic              rd_req, wr_req, rsp_ok, rsp_err, drv_oe, drv_bit;
    logic [ADDR_W-1:0] req_adr;
    logic [DATA_W-1:0] wr_data, rsp_data;

    mdio_frame_fsm #(.PRE_LEN(PRE_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst(rst), .ce(ce), .mdio_i(mdio_i), .phy_addr(phy_addr),
        .rsp_ok(rsp_ok), .rsp_err(rsp_err), .rsp_data(rsp_data),
        .rd_req(rd_req), .wr_req(wr_req), .req_adr(req_adr), .wr_data(wr_data),
        .drv_oe(drv_oe), .drv_bit(drv_bit)
    );

    mdio_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req),
        .req_adr(req_adr), .wr_data(wr_data),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
        .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_adr(bus_adr), .bus_wdata(bus_wdata),
        .rsp_ok(rsp_ok), .rsp_err(rsp_err), .rsp_data(rsp_data)
    );

    mdio_out_delay #(.STAGES(OUT_STAGES)) u_dly (
        .clk(clk), .rst(rst), .oe_in(drv_oe), .bit_in(drv_bit),
        .oe_out(mdio_oe), .bit_out(mdio_o)
    );

    AST_NO_DRIVE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> !bus_cyc); // R3
    AST_DRIVE_NEEDS_GOOD_RSP: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_oe) |-> (rsp_ok && !rsp_err)); // R7
endmodule

// File: tb/mdio_bus_bridge_bench.sv
module mdio_bus_bridge_bench;
    localparam logic [4:0] PHY = 5'h05;
    localparam int ERR_BASE = 24;

    logic clk = 1'b0;
    logic rst = 1'b1, ce = 1'b0, mdio_i = 1'b1;
    logic mdio_o, mdio_oe, bus_cyc, bus_stb, bus_we;
    logic [4:0]  bus_adr;
    logic [15:0] bus_wdata, bus_rdata;
    logic bus_ack = 1'b0, bus_err = 1'b0;

    always #5 clk = ~clk;

    mdio_bus_bridge u_mdio_bus_bridge (
        .clk(clk), .rst(rst), .ce(ce), .mdio_i(mdio_i), .phy_addr(PHY),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
        .bus_we(bus_we), .bus_adr(bus_adr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err)
    );

    function automatic logic [15:0] rd_model(input logic [4:0] a);
        return 16'hC35A ^ (16'(a) * 16'h0421);
    endfunction
    function automatic logic [15:0] wr_model(input logic [4:0] a);
        return 16'h1E0F ^ (16'(a) * 16'h0813);
    endfunction

    assign bus_rdata = rd_model(bus_adr);

    // bench slave: responds on the second clock of a cycle
    logic [1:0]  wcnt = 2'd0;
    int          wr_cnt = 0, starts = 0, cyc_clks = 0;
    logic        cyc_d = 1'b0;
    logic [4:0]  last_wadr = '0;
    logic [15:0] last_wdat = '0;
    always @(posedge clk) begin
        cyc_d <= bus_cyc;
        if (bus_cyc) cyc_clks <= cyc_clks + 1;
        if (bus_cyc && !cyc_d) starts <= starts + 1;
        bus_ack <= 1'b0;
        bus_err <= 1'b0;
        if (!rst && bus_cyc && bus_stb && !bus_ack && !bus_err) begin
            if (wcnt == 2'd1) begin
                wcnt <= 2'd0;
                if (int'(bus_adr) >= ERR_BASE) bus_err <= 1'b1;
                else begin
                    bus_ack <= 1'b1;
                    if (bus_we) begin
                        wr_cnt <= wr_cnt + 1;
                        last_wadr <= bus_adr;
                        last_wdat <= bus_wdata;
                    end
                end
            end else wcnt <= wcnt + 2'd1;
        end
    end

    int tests = 0, fails = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    logic s_oe2, s_oe3, s_oe, s_o;
    task automatic tick_bit(input logic b);
        @(negedge clk); mdio_i = b; ce = 1'b1;
        @(negedge clk); ce = 1'b0;
        @(negedge clk); s_oe2 = mdio_oe;
        @(negedge clk); s_oe3 = mdio_oe;
        repeat (4) @(negedge clk);
        s_oe = mdio_oe; s_o = mdio_o;
    endtask

    logic [17:0] oe_v, o_v;
    logic ta_n2, ta_n3;
    task automatic run_frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                             input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd);
        tick_bit(1'b0);
        for (int i = 0; i < pre; i++) tick_bit(1'b1);
        tick_bit(st[1]); tick_bit(st[0]);
        tick_bit(op[1]); tick_bit(op[0]);
        for (int i = 4; i >= 0; i--) tick_bit(pa[i]);
        for (int i = 4; i >= 0; i--) tick_bit(ra[i]);
        tick_bit(1'b1);
        ta_n2 = s_oe2; ta_n3 = s_oe3; oe_v[0] = s_oe; o_v[0] = s_o;
        tick_bit(op == 2'b10 ? 1'b1 : 1'b0);
        oe_v[1] = s_oe; o_v[1] = s_o;
        for (int i = 15; i >= 0; i--) begin
            tick_bit(op == 2'b10 ? 1'b1 : wd[i]);
            oe_v[17-i] = s_oe; o_v[17-i] = s_o;
        end
    endtask

    task automatic good_read(input logic [4:0] ra, input string tag);
        logic [15:0] d;
        logic [15:0] exp;
        int s0, c0;
        s0 = starts; c0 = cyc_clks;
        run_frame(32, 2'b01, 2'b10, PHY, ra, 16'h0);
        exp = rd_model(ra);
        for (int k = 1; k <= 16; k++) d[16-k] = o_v[k];
        if (int'(ra) < ERR_BASE) begin
            chk(d == exp && o_v[0] == 1'b0, {tag, " R3 read data"}, {16'h0, d}, {16'h0, exp});
            chk(oe_v == 18'h0FFFF || oe_v == 18'h1FFFF ? oe_v == 18'h1FFFF : 1'b0,
                {tag, " R3 enable window"}, {14'h0, oe_v}, 32'h1FFFF);
            chk(ta_n2 == 1'b0 && ta_n3 == 1'b1, {tag, " R9 two-clock lag"},
                {30'h0, ta_n2, ta_n3}, 32'h1);
        end else begin
            chk(oe_v == 18'h0, {tag, " R7 no drive on bus error"}, {14'h0, oe_v}, 32'h0);
        end
        chk(starts == s0 + 1 && cyc_clks == c0 + 3, {tag, " R10 one cycle held 3 clocks"},
            32'(cyc_clks - c0), 32'd3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog got=hang exp=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int s0, w0;
        repeat (4) @(negedge clk);
        chk(mdio_oe == 1'b0 && bus_cyc == 1'b0, "R1 reset outputs", {30'h0, mdio_oe, bus_cyc}, 32'h0);
        rst = 1'b0;

        // R3 / R7: read sweep over every register
        for (int r = 0; r < 32; r++) good_read(5'(r), "sweep");

        // R4 / R8: write sweep over every register
        for (int r = 0; r < 32; r++) begin
            w0 = wr_cnt; s0 = starts;
            run_frame(32, 2'b01, 2'b01, PHY, 5'(r), wr_model(5'(r)));
            if (r < ERR_BASE)
                chk(wr_cnt == w0 + 1 && last_wadr == 5'(r) && last_wdat == wr_model(5'(r)),
                    "R4 write", {11'h0, last_wadr, last_wdat}, {11'h0, 5'(r), wr_model(5'(r))});
            else
                chk(wr_cnt == w0 && starts == s0 + 1 && oe_v == 18'h0,
                    "R8 error write ignored", 32'(wr_cnt - w0), 32'd0);
        end
        good_read(5'd3, "R8 after error write");

        // R5: every other PHY address, read and one write
        for (int p = 0; p < 32; p++) begin
            if (5'(p) != PHY) begin
                s0 = starts;
                run_frame(32, 2'b01, 2'b10, 5'(p), 5'(p), 16'h0);
                chk(starts == s0 && oe_v == 18'h0, "R5 foreign address read", 32'(starts - s0), 32'd0);
            end
        end
        s0 = starts;
        run_frame(32, 2'b01, 2'b01, 5'h1A, 5'd2, 16'h1234);
        chk(starts == s0, "R5 foreign address write", 32'(starts - s0), 32'd0);
        good_read(5'd9, "R5 resync");

        // R6: bad opcodes and bad start pair
        s0 = starts;
        run_frame(32, 2'b01, 2'b00, PHY, 5'd4, 16'h0);
        chk(starts == s0, "R6 opcode 00", 32'(starts - s0), 32'd0);
        good_read(5'd4, "R6 after opcode 00");
        s0 = starts;
        run_frame(32, 2'b01, 2'b11, PHY, 5'd4, 16'h0);
        chk(starts == s0 && oe_v == 18'h0, "R6 opcode 11", 32'(starts - s0), 32'd0);
        good_read(5'd5, "R6 after opcode 11");
        s0 = starts;
        run_frame(32, 2'b00, 2'b01, PHY, 5'd6, 16'h0F0F);
        chk(starts == s0, "R6 start pair 00", 32'(starts - s0), 32'd0);
        good_read(5'd6, "R6 after bad start");

        // R2: preamble one short
        s0 = starts;
        run_frame(31, 2'b01, 2'b01, PHY, 5'd7, 16'h0101);
        chk(starts == s0, "R2 short preamble", 32'(starts - s0), 32'd0);
        good_read(5'd7, "R2 exact preamble");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule